// File: doc/BRIEF.md
# Interval Timer Host Register Sequencer

This block is the byte-wide host side of a three-channel interval timer. A host reaches it through a 2-bit address, an 8-bit write bus and an 8-bit read bus, with separate write and read strobes. Address 3 is the command port. Addresses 0, 1 and 2 each reach the count register of one channel. The counting channels sit outside the block. They present their live 16-bit counts to it, and they take from it a one-cycle load strobe with a 16-bit load value.

Each channel has a small sequencer. It remembers the channel's counting mode, its BCD flag and its byte access pattern. The host can write or read only the low byte, only the high byte, or the low byte followed by the high byte. A freeze command takes a snapshot of the live count, which the host then reads out as two bytes while the counter keeps running.

Top module: `tmr_host_seq`

## Requirements
- R1: After reset, every channel reports counting mode 3 and BCD 0, uses the low-then-high access pattern with the low byte next for both reads and writes, holds no snapshot, and drives no load strobe.
- R2: A command (write to address 3) whose bits 5:4 are nonzero programs the channel in bits 7:6. That channel's counting mode becomes bits 3:1 and its BCD flag becomes bit 0 from the next cycle on. The other channels keep their settings.
- R3: A command whose channel field (bits 7:6) is 3 changes no mode, no flag, no byte order and no snapshot, and loads nothing.
- R4: In access pattern 1 (low only), a data write pulses that channel's load strobe for one cycle, starting the cycle after the write, with load value {8'h00, byte}.
- R5: In access pattern 2 (high only), a data write loads {byte, 8'h00}.
- R6: In access pattern 3 (low then high), the first data write loads nothing. The second loads {second byte, first byte}.
- R7: A programming command restarts the channel's write order and read order at the low byte.
- R8: Reads without a snapshot return the live count: the low byte in pattern 1, the high byte in pattern 2, and in pattern 3 the low byte then the high byte, alternating.
- R9: A command with bits 5:4 equal to 0 freezes the addressed channel's live count. The next two reads of that channel return the frozen low byte and then the frozen high byte, whatever the live count does meanwhile.
- R10: Once both frozen bytes have been read, reads follow the programmed pattern again.
- R11: A freeze command for a channel whose snapshot is not yet fully read is ignored.
- R12: A read of address 3 returns 8'hFF and changes no channel state.
- R13: A load strobe goes only to the channel whose address was written, and no more than one channel strobes in a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 to 2 select a channel, 3 is the command port |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; the read advances byte order at the clock edge |
| rdata | output | 8 | Read byte for the current address, combinational |
| cnt_in | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| load_stb | output | 3 | One-cycle load pulse for each channel |
| load_val | output | 48 | 16-bit load value for each channel, channel 0 in the low bits |
| ch_mode | output | 9 | 3-bit counting mode of each channel |
| ch_bcd | output | 3 | BCD flag of each channel |

## Verification
The sequencer holds no more than a byte pointer, a held low byte and a snapshot for each channel. A wrong internal state therefore shows up at the ports on the very next access to that channel. A stuck or flipped byte pointer returns the wrong half of the count, or loads a value with its halves swapped. A snapshot that is released too early or too late shows the live count where the frozen one was due, or the reverse. The bench checks these with live counts whose two bytes differ, and it changes those counts between a freeze and its readout. It also interleaves command-port reads and ignored commands, to show that they leave every pointer where it was.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    localparam logic [1:0]        CMD_ADDR  = 2'd3;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'd0,
        ACC_LO     = 2'd1,
        ACC_HI     = 2'd2,
        ACC_WORD   = 2'd3
    } acc_e;

    typedef struct packed {
        logic [1:0]        chan;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } cmd_t;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              wr_hi;
        logic              rd_hi;
        logic              snap_vld;
        logic              snap_hi;
    } chan_st_t;

    function automatic cmd_t split_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.chan = b[7:6];
        c.acc  = acc_e'(b[5:4]);
        c.mode = b[3:1];
        c.bcd  = b[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                    input logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_cmd_dec.sv
`timescale 1ns/1ps
module tmr_cmd_dec
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [NCH-1:0]    pgm,
    output logic [NCH-1:0]    freeze,
    output logic [NCH-1:0]    dat_wr,
    output logic [NCH-1:0]    dat_rd,
    output acc_e              cmd_acc,
    output logic [MODE_W-1:0] cmd_mode,
    output logic              cmd_bcd
);
    cmd_t cw;
    logic is_cmd;

    assign cw       = split_cmd(wdata);
    assign is_cmd   = wr_en && (addr == CMD_ADDR);
    assign cmd_acc  = cw.acc;
    assign cmd_mode = cw.mode;
    assign cmd_bcd  = cw.bcd;

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        logic hit_cmd;
        assign hit_cmd   = is_cmd && (cw.chan == 2'(i));
        assign pgm[i]    = hit_cmd && (cw.acc != ACC_FREEZE);
        assign freeze[i] = hit_cmd && (cw.acc == ACC_FREEZE);
        assign dat_wr[i] = wr_en && (addr == 2'(i));
        assign dat_rd[i] = rd_en && (addr == 2'(i));
    end

endmodule

// File: rtl/tmr_chan_seq.sv
`timescale 1ns/1ps
module tmr_chan_seq
    import tmr_pkg::*;
#(
    parameter logic [MODE_W-1:0] RST_MODE = 3'd3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm,
    input  logic              freeze,
    input  acc_e              cmd_acc,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic              cmd_bcd,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o
);
    chan_st_t          st;
    logic [BYTE_W-1:0] lo_hold;
    logic [CNT_W-1:0]  snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '{acc: ACC_WORD, mode: RST_MODE, bcd: 1'b0,
                          wr_hi: 1'b0, rd_hi: 1'b0, snap_vld: 1'b0, snap_hi: 1'b0};
            lo_hold  <= '0;
            snap     <= '0;
            load_stb <= 1'b0;
            load_val <= '0;
        end else begin
            load_stb <= 1'b0;
            if (pgm) begin
                st.acc      <= cmd_acc;
                st.mode     <= cmd_mode;
                st.bcd      <= cmd_bcd;
                st.wr_hi    <= 1'b0;
                st.rd_hi    <= 1'b0;
                st.snap_vld <= 1'b0;
                st.snap_hi  <= 1'b0;
            end else if (freeze && !st.snap_vld) begin
                snap        <= live_cnt;
                st.snap_vld <= 1'b1;
                st.snap_hi  <= 1'b0;
            end

            if (dat_wr) begin
                unique case (st.acc)
                    ACC_LO: begin
                        load_stb <= 1'b1;
                        load_val <= {{BYTE_W{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        load_stb <= 1'b1;
                        load_val <= {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (st.wr_hi) begin
                            load_stb <= 1'b1;
                            load_val <= {wdata, lo_hold};
                            st.wr_hi <= 1'b0;
                        end else begin
                            lo_hold  <= wdata;
                            st.wr_hi <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (dat_rd && !pgm) begin
                if (st.snap_vld) begin
                    st.snap_hi <= !st.snap_hi;
                    if (st.snap_hi) st.snap_vld <= 1'b0;
                end else if (st.acc == ACC_WORD) begin
                    st.rd_hi <= !st.rd_hi;
                end
            end
        end
    end

    always_comb begin
        if (st.snap_vld) begin
            rd_byte = pick_byte(snap, st.snap_hi);
        end else begin
            unique case (st.acc)
                ACC_HI:   rd_byte = pick_byte(live_cnt, 1'b1);
                ACC_WORD: rd_byte = pick_byte(live_cnt, st.rd_hi);
                default:  rd_byte = pick_byte(live_cnt, 1'b0);
            endcase
        end
    end

    assign mode_o = st.mode;
    assign bcd_o  = st.bcd;

    // R4: a load pulse always follows a data write to this channel
    a_r4_load_after_write: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> $past(dat_wr));

    // R6: the first byte of a two-byte write must not load
    a_r6_first_half_quiet: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && st.acc == ACC_WORD && !st.wr_hi) |=> !load_stb);

    // R11: a freeze while a snapshot is pending leaves the snapshot alone
    a_r11_snap_kept: assert property (@(posedge clk) disable iff (rst)
        (freeze && st.snap_vld && !pgm) |=> $stable(snap));

    // R10: reading the frozen high byte releases the snapshot
    a_r10_snap_release: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && st.snap_vld && st.snap_hi) |=> !st.snap_vld);

endmodule

// File: rtl/tmr_host_seq.sv
`timescale 1ns/1ps
module tmr_host_seq
    import tmr_pkg::*;
#(
    parameter int                NCH      = 3,
    parameter logic [MODE_W-1:0] RST_MODE = 3'd3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  wr_en,
    input  logic                  rd_en,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [NCH*CNT_W-1:0]  cnt_in,
    output logic [NCH-1:0]        load_stb,
    output logic [NCH*CNT_W-1:0]  load_val,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]        ch_bcd
);
    logic [NCH-1:0]    pgm, freeze, dat_wr, dat_rd;
    acc_e              cmd_acc;
    logic [MODE_W-1:0] cmd_mode;
    logic              cmd_bcd;
    logic [BYTE_W-1:0] rd_b [NCH];

    tmr_cmd_dec #(.NCH(NCH)) u_dec (
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .pgm      (pgm),
        .freeze   (freeze),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .cmd_acc  (cmd_acc),
        .cmd_mode (cmd_mode),
        .cmd_bcd  (cmd_bcd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan_seq #(.RST_MODE(RST_MODE)) u_seq (
            .clk      (clk),
            .rst      (rst),
            .pgm      (pgm[i]),
            .freeze   (freeze[i]),
            .cmd_acc  (cmd_acc),
            .cmd_mode (cmd_mode),
            .cmd_bcd  (cmd_bcd),
            .dat_wr   (dat_wr[i]),
            .dat_rd   (dat_rd[i]),
            .wdata    (wdata),
            .live_cnt (cnt_in[i*CNT_W +: CNT_W]),
            .rd_byte  (rd_b[i]),
            .load_stb (load_stb[i]),
            .load_val (load_val[i*CNT_W +: CNT_W]),
            .mode_o   (ch_mode[i*MODE_W +: MODE_W]),
            .bcd_o    (ch_bcd[i])
        );
    end

    always_comb begin
        rdata = IDLE_BYTE;
        for (int i = 0; i < NCH; i++) begin
            if (addr == 2'(i)) rdata = rd_b[i];
        end
    end

    // R13: at most one channel loads in any cycle
    a_r13_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_stb));

    // R12: the command port reads back as all ones
    a_r12_cmd_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == CMD_ADDR) |-> (rdata == IDLE_BYTE));

    // R3: a command naming channel 3 changes no setting and loads nothing
    a_r3_ch3_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CMD_ADDR && wdata[7:6] == 2'd3)
        |=> ($stable(ch_mode) && $stable(ch_bcd) && load_stb == '0));

endmodule

// File: tb/tmr_host_seq_test.sv
`timescale 1ns/1ps
module tmr_host_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [47:0] cnt_in;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [15:0] cnt [3];

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    typedef struct {
        int          ch;
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t expq[$];

    assign cnt_in = {cnt[2], cnt[1], cnt[0]};

    always #5 clk = ~clk;

    tmr_host_seq uut (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .cnt_in   (cnt_in),
        .load_stb (load_stb),
        .load_val (load_val),
        .ch_mode  (ch_mode),
        .ch_bcd   (ch_bcd)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every load strobe must match the next queued item
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 3; c++) begin
                if (load_stb[c]) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R13 unexpected load", 16'(c), 16'hFFFF);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(c == e.ch, {e.tag, " load channel"}, 16'(c), 16'(e.ch));
                        chk(load_val[c*16 +: 16] == e.val, {e.tag, " load value"},
                            load_val[c*16 +: 16], e.val);
                    end
                end
            end
        end
    end

    task automatic push_load(input int ch, input logic [15:0] v, input string tag);
        exp_t e;
        e.ch = ch; e.val = v; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(rdata == exp, tag, 16'(rdata), 16'(exp));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 16'h0, 16'h0);
            finish_run();
        end
    end

    initial begin
        cnt[0] = 16'h1234;
        cnt[1] = 16'hBEEF;
        cnt[2] = 16'h9A3B;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(load_stb == 3'b000, "R1 no load strobe", 16'(load_stb), 16'h0);
        chk(ch_mode == {3'd3, 3'd3, 3'd3}, "R1 modes", 16'(ch_mode), 16'(9'o333));
        chk(ch_bcd == 3'b000, "R1 bcd", 16'(ch_bcd), 16'h0);
        rd(2'd0, 8'h34, "R1 R8 word read low first");
        rd(2'd0, 8'h12, "R8 word read high second");

        // R2 program channel 1: low only, mode 2, bcd 1
        wr(2'd3, 8'b01_01_010_1);
        chk(ch_mode[5:3] == 3'd2, "R2 ch1 mode", 16'(ch_mode[5:3]), 16'd2);
        chk(ch_bcd[1] == 1'b1, "R2 ch1 bcd", 16'(ch_bcd[1]), 16'd1);
        chk(ch_mode[2:0] == 3'd3 && ch_mode[8:6] == 3'd3, "R2 others kept",
            16'(ch_mode), 16'(9'o323));

        // R4 low-only load; R13 routed to channel 1
        push_load(1, 16'h00A7, "R4 R13");
        wr(2'd1, 8'hA7);
        rd(2'd1, 8'hEF, "R8 low-only read");
        rd(2'd1, 8'hEF, "R8 low-only read repeats");

        // R3 channel 3 command ignored
        wr(2'd3, 8'hFF);
        chk(ch_mode == {3'd3, 3'd2, 3'd3}, "R3 modes unchanged", 16'(ch_mode), 16'(9'o323));
        chk(ch_bcd == 3'b010, "R3 bcd unchanged", 16'(ch_bcd), 16'h2);
        rd(2'd0, 8'h34, "R3 ch0 order unchanged");
        rd(2'd0, 8'h12, "R8 ch0 high");

        // R5 high-only on channel 2
        wr(2'd3, 8'b10_10_000_0);
        push_load(2, 16'h5C00, "R5");
        wr(2'd2, 8'h5C);
        rd(2'd2, 8'h9A, "R8 high-only read");

        // R6 two-byte write on channel 0, mode 4
        wr(2'd3, 8'b00_11_100_0);
        chk(ch_mode[2:0] == 3'd4, "R2 ch0 mode 4", 16'(ch_mode[2:0]), 16'd4);
        wr(2'd0, 8'h11);
        push_load(0, 16'h2211, "R6");
        wr(2'd0, 8'h22);

        // R7 reprogramming restarts write order
        wr(2'd0, 8'h44);
        wr(2'd3, 8'b00_11_100_0);
        wr(2'd0, 8'h55);
        push_load(0, 16'h6655, "R7 write order");
        wr(2'd0, 8'h66);

        // R7 reprogramming restarts read order
        rd(2'd0, 8'h34, "R7 read low");
        wr(2'd3, 8'b00_11_100_0);
        rd(2'd0, 8'h34, "R7 read restarts low");
        rd(2'd0, 8'h12, "R8 read high");

        // R9 freeze channel 0, live count then moves
        wr(2'd3, 8'b00_00_0000);
        cnt[0] = 16'h5678;
        rd(2'd0, 8'h34, "R9 frozen low");
        // R11 second freeze while pending
        cnt[0] = 16'hAB99;
        wr(2'd3, 8'b00_00_0000);
        rd(2'd0, 8'h12, "R9 R11 frozen high kept");
        // R10 back to live word reads
        rd(2'd0, 8'h99, "R10 live low after snapshot");
        // R12 command port reads do not advance order
        rd(2'd3, 8'hFF, "R12 command port read");
        rd(2'd0, 8'hAB, "R12 R10 live high next");

        // R9 R10 freeze on low-only channel 1
        wr(2'd3, 8'b01_00_0000);
        cnt[1] = 16'h0000;
        rd(2'd1, 8'hEF, "R9 ch1 frozen low");
        rd(2'd1, 8'hBE, "R9 ch1 frozen high");
        rd(2'd1, 8'h00, "R10 ch1 live low");

        // R12 freeze pending survives command-port read on channel 2
        wr(2'd3, 8'b10_00_0000);
        cnt[2] = 16'h0000;
        rd(2'd3, 8'hFF, "R12 read while frozen");
        rd(2'd2, 8'h3B, "R12 R9 ch2 frozen low");
        rd(2'd2, 8'h9A, "R9 ch2 frozen high");
        rd(2'd2, 8'h00, "R10 ch2 live high");

        // R13 another low-only load, only channel 1 strobes
        push_load(1, 16'h0033, "R13 second");
        wr(2'd1, 8'h33);

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R4 R5 R6 expected loads seen",
            16'(expq.size()), 16'h0);
        done = 1'b1;
        finish_run();
    end

endmodule